// File: doc/BRIEF.md
# Serial ADC Conversion Capture Controller

This block runs conversions on a 12-bit serial sampling converter. When a start request is accepted, it pulls the active-low convert strobe down, which puts the converter into hold. It then toggles a gated serial clock made by dividing the system clock. The converter's data line has a pull-up and floats high between conversions. The controller samples the line on each rising serial-clock edge. The first rising edge that reads low is taken as the conversion's start marker. The next twelve rising edges supply the result, most significant bit first. This frame alignment absorbs the one-cycle uncertainty in where the conversion starts, which arises when the strobe and the serial clock are not in a fixed phase.

After the last bit the controller lets the serial clock finish its high phase and parks it low. In the same cycle it raises the strobe, which returns the converter to sample mode. The word is then offered on a valid/ready output. The word and valid stay fixed until the consumer accepts them. Back-pressure is handled by refusing new start requests while a result is still pending, so a stalled consumer stalls conversions and no sample is ever lost. After every conversion the strobe stays high for an acquisition delay before a new request is accepted. If no start marker arrives within a set number of serial clocks, the controller gives up, parks the clock, raises the strobe and pulses an error flag.

Top module: `adc_serial_capture`

## Requirements
- R1: During and after reset the strobe is high, the serial clock is low, and res_valid and timeout_err are low. A start request held from reset release makes the strobe fall on clock edge ACQ_CYCLES+1 after release.
- R2: An accepted start request lowers the strobe on the next clock edge. The serial clock first rises DIV_HALF clock cycles later, and each low and high phase then lasts DIV_HALF clock cycles.
- R3: The start marker is the first rising serial-clock edge at which the data line reads 0. A marker found at any of rising edges 1 to MARK_LIMIT is accepted.
- R4: The 12 rising edges after the marker capture the result, MSB first. Bit 11 of res_data is the first bit captured after the marker.
- R5: After the 12th bit, the serial clock falls after its normal high phase and stays low. The strobe rises on that same edge, and res_valid rises on that edge with the captured word.
- R6: While res_valid is high and res_ready is low, res_valid stays high and res_data is unchanged. The transfer completes on a clock edge with both high, and res_valid is low afterwards.
- R7: A start request is ignored while a conversion is in progress, during the acquisition delay, or while res_valid is high.
- R8: If MARK_LIMIT rising edges all read 1, timeout_err pulses for exactly one cycle. The strobe rises at the end of that serial-clock high phase, and no result is presented.
- R9: Between conversions the strobe stays high for at least ACQ_CYCLES+1 clock cycles. With a request pending and the result already taken, it is high for exactly that long.
- R10: The serial clock is low whenever the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, sampled when the controller is idle |
| adc_sdata | input | 1 | Serial data from the converter (pulled high when floating) |
| res_ready | input | 1 | Consumer accepts the result |
| adc_conv_n | output | 1 | Active-low convert strobe (low = hold/convert) |
| adc_sclk | output | 1 | Gated serial clock to the converter |
| res_valid | output | 1 | Result word available |
| res_data | output | DATA_W | Captured result, MSB first on the wire |
| timeout_err | output | 1 | One-cycle pulse when no start marker arrives |

## Verification
The properties assume that the data line changes only just after a falling serial-clock edge. They also assume it is stable for at least two system clocks before the next rising edge, which requires DIV_HALF of three or more because of the two-stage synchronizer. They further assume that start and res_ready are synchronous to clk. The bench's converter model meets these conditions. It reacts to the strobe falling and to each falling serial-clock edge, changes the line one nanosecond later, and releases it to the pulled-up level when the strobe rises. The marker offset is varied from zero to past the timeout limit, and the consumer's ready is withheld for several cycles.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  typedef enum logic [2:0] {
    ST_ACQ,     // strobe high, acquisition delay running
    ST_IDLE,    // waiting for a request
    ST_MARK,    // clocking, looking for the low start marker
    ST_DATA,    // shifting in result bits
    ST_FINISH,  // last bit taken, waiting for the clock to fall
    ST_ABORT    // marker timed out, waiting for the clock to fall
  } cap_state_e;
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int DIV_HALF = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = $clog2(DIV_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  always_comb begin
    tick     = run && (cnt == LAST);
    rise_evt = tick && !sclk;
    fall_evt = tick && sclk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_bit_shifter.sv
module adc_bit_shifter #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      word <= '0;
    end else if (shift_en) begin
      word <= {word[DATA_W-2:0], bit_in};
    end
  end
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_serial_capture.sv
module adc_serial_capture
  import adc_cap_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int DIV_HALF   = 8,
  parameter int MARK_LIMIT = 4,
  parameter int ACQ_CYCLES = 44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adc_sdata,
  input  logic              res_ready,
  output logic              adc_conv_n,
  output logic              adc_sclk,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              timeout_err
);
  localparam int MW = $clog2(MARK_LIMIT + 1);
  localparam int BW = $clog2(DATA_W + 1);
  localparam int AW = $clog2(ACQ_CYCLES + 1);
  localparam logic [MW-1:0] MARK_LAST = MW'(MARK_LIMIT - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_W - 1);
  localparam logic [AW-1:0] ACQ_LAST  = AW'(ACQ_CYCLES - 1);

  cap_state_e        state;
  logic [MW-1:0]     mark_cnt;
  logic [BW-1:0]     bit_cnt;
  logic [AW-1:0]     acq_cnt;
  logic              conv_n_q, err_q;
  logic              sync1, sync2;
  logic              run, rise_evt, fall_evt;
  logic              shift_en, load, clr;
  logic [DATA_W-1:0] word;

  // two-stage synchronizer; reset to the pulled-up level
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= adc_sdata;
      sync2 <= sync1;
    end
  end

  always_comb begin
    run      = (state == ST_MARK) || (state == ST_DATA) ||
               (state == ST_FINISH) || (state == ST_ABORT);
    shift_en = (state == ST_DATA) && rise_evt;
    load     = (state == ST_FINISH) && fall_evt;
    clr      = (state == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_ACQ;
      acq_cnt  <= '0;
      mark_cnt <= '0;
      bit_cnt  <= '0;
      conv_n_q <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state)
        ST_ACQ: begin
          if (acq_cnt == ACQ_LAST) begin
            state   <= ST_IDLE;
            acq_cnt <= '0;
          end else begin
            acq_cnt <= acq_cnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (start && !res_valid) begin
            state    <= ST_MARK;
            conv_n_q <= 1'b0;
            mark_cnt <= '0;
            bit_cnt  <= '0;
          end
        end
        ST_MARK: begin
          if (rise_evt) begin
            if (!sync2) begin
              state <= ST_DATA;
            end else if (mark_cnt == MARK_LAST) begin
              state <= ST_ABORT;
              err_q <= 1'b1;
            end else begin
              mark_cnt <= mark_cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (rise_evt) begin
            if (bit_cnt == BIT_LAST) state <= ST_FINISH;
            else                     bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_FINISH, ST_ABORT: begin
          if (fall_evt) begin
            state    <= ST_ACQ;
            conv_n_q <= 1'b1;
            acq_cnt  <= '0;
          end
        end
        default: state <= ST_ACQ;
      endcase
    end
  end

  adc_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sclk(adc_sclk), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  adc_bit_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift_en),
    .bit_in(sync2), .word(word)
  );

  adc_result_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load), .din(word),
    .ready(res_ready), .valid(res_valid), .dout(res_data)
  );

  assign adc_conv_n  = conv_n_q;
  assign timeout_err = err_q;
endmodule

// File: rtl/adc_capture_checker.sv
module adc_capture_checker #(
  parameter int DATA_W     = 12,
  parameter int DIV_HALF   = 8,
  parameter int ACQ_CYCLES = 44
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adc_conv_n,
  input logic              adc_sclk,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data,
  input logic              timeout_err
);
  localparam int PW = $clog2(DIV_HALF + 2);
  localparam int HW = $clog2(ACQ_CYCLES + 2);

  logic          sclk_last;
  logic [PW-1:0] ph_cnt;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_last <= 1'b0;
      ph_cnt    <= '0;
      hi_cnt    <= '0;
    end else begin
      sclk_last <= adc_sclk;
      if (adc_sclk != sclk_last)          ph_cnt <= PW'(1);
      else if (ph_cnt != PW'(DIV_HALF))   ph_cnt <= ph_cnt + 1'b1;
      if (!adc_conv_n)                    hi_cnt <= '0;
      else if (hi_cnt != HW'(ACQ_CYCLES)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  p_sclk_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sclk != sclk_last) |-> (ph_cnt >= PW'(DIV_HALF)));

  p_valid_at_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> (adc_conv_n && !adc_sclk));

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  p_err_no_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> !res_valid);

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> !timeout_err);

  p_acq_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_conv_n && (hi_cnt < HW'(ACQ_CYCLES))) |=> adc_conv_n);

  p_sclk_parked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv_n |-> !adc_sclk);
endmodule

bind adc_serial_capture adc_capture_checker #(
  .DATA_W(DATA_W), .DIV_HALF(DIV_HALF), .ACQ_CYCLES(ACQ_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_conv_n(adc_conv_n), .adc_sclk(adc_sclk),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .timeout_err(timeout_err)
);

// File: tb/adc_serial_capture_tb.sv
module adc_serial_capture_tb;
  localparam int W   = 12;
  localparam int DH  = 8;
  localparam int ML  = 4;
  localparam int ACQ = 44;
  localparam int NV  = 8;
  // [31:24] marker offset in falling edges, [23:16] ready delay, [11:0] word
  localparam logic [31:0] VEC [NV] = '{
    {8'd0, 8'd0, 4'd0, 12'hA5C}, {8'd1, 8'd3, 4'd0, 12'hFFF},
    {8'd2, 8'd0, 4'd0, 12'h000}, {8'd3, 8'd5, 4'd0, 12'h801},
    {8'd4, 8'd0, 4'd0, 12'h123}, {8'd1, 8'd0, 4'd0, 12'h001},
    {8'd9, 8'd0, 4'd0, 12'h555}, {8'd0, 8'd2, 4'd0, 12'h7FE}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sdata = 1'b1, ready = 1'b1;
  logic adc_conv_n, adc_sclk, res_valid, timeout_err;
  logic [W-1:0] res_data;
  int checks = 0, fails = 0, r10_bad = 0;
  int model_k = 0;
  logic [W-1:0] model_word = '0;

  always #4 clk = ~clk;

  adc_serial_capture #(.DATA_W(W), .DIV_HALF(DH), .MARK_LIMIT(ML), .ACQ_CYCLES(ACQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .adc_sdata(sdata), .res_ready(ready),
    .adc_conv_n(adc_conv_n), .adc_sclk(adc_sclk), .res_valid(res_valid),
    .res_data(res_data), .timeout_err(timeout_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input int f);
    if (f == model_k) sdata = 1'b0;
    else if (f > model_k && f <= model_k + W) sdata = model_word[W-1-(f-model_k-1)];
    else sdata = 1'b1;
  endtask

  // converter model: line changes just after each falling serial-clock edge
  initial begin
    forever begin
      @(negedge adc_conv_n);
      #1 drive(0);
      for (int f = 1; !adc_conv_n; ) begin
        @(negedge adc_sclk or posedge adc_conv_n);
        if (!adc_conv_n) begin
          #1 drive(f);
          f++;
        end
      end
      sdata = 1'b1;
    end
  end

  always @(negedge clk) if (rst_n && adc_conv_n && adc_sclk) r10_bad++;

  task automatic wait_conv_low(output bit ok);
    ok = 0;
    for (int i = 0; i < 400 && !ok; i++) begin
      @(negedge clk);
      if (!adc_conv_n) ok = 1;
    end
  endtask

  task automatic wait_outcome(output bit v, output bit e);
    v = 0; e = 0;
    for (int i = 0; i < 3000 && !v && !e; i++) begin
      @(negedge clk);
      if (res_valid) v = 1;
      if (timeout_err) e = 1;
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    bit ok, v, e;
    int n;
    // R1 reset state
    repeat (6) @(negedge clk);
    chk(adc_conv_n && !adc_sclk && !res_valid && !timeout_err, "R1 reset outputs",
        {adc_conv_n, adc_sclk, res_valid, timeout_err}, 4'b1000);
    model_k = 0; model_word = 12'h3C3; ready = 1'b0; start = 1'b1;
    rst_n = 1'b1;
    n = 0;
    for (int i = 1; i < 400 && n == 0; i++) begin
      @(negedge clk);
      if (!adc_conv_n) n = i;
    end
    start = 1'b0;
    chk(n == ACQ + 1, "R1 first strobe fall after reset", n, ACQ + 1);
    // R2 clock timing
    n = 0;
    for (int i = 1; i < 100 && n == 0; i++) begin @(negedge clk); if (adc_sclk) n = i; end
    chk(n == DH, "R2 strobe to first sclk rise", n, DH);
    n = 0;
    for (int i = 1; i < 100 && n == 0; i++) begin @(negedge clk); if (!adc_sclk) n = i; end
    chk(n == DH, "R2 sclk high phase", n, DH);
    n = 0;
    for (int i = 1; i < 100 && n == 0; i++) begin @(negedge clk); if (adc_sclk) n = i; end
    chk(n == DH, "R2 sclk low phase", n, DH);
    // R7 request during conversion is ignored
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_outcome(v, e);
    chk(v && res_data == 12'h3C3, "R4 word with busy request", res_data, 12'h3C3);
    // R7 request while result pending is ignored
    start = 1'b1;
    ok = 1;
    for (int i = 0; i < 150; i++) begin @(negedge clk); if (!adc_conv_n) ok = 0; end
    start = 1'b0;
    chk(ok && res_valid, "R7 no start while result pending", ok, 1);
    ready = 1'b1; @(negedge clk);
    chk(!res_valid, "R6 accept clears valid", res_valid, 0);
    // R9 exact gap with continuous request
    model_k = 1; model_word = 12'h9A6; start = 1'b1;
    wait_conv_low(ok);
    wait_outcome(v, e);
    chk(v && res_data == 12'h9A6, "R4 word before gap", res_data, 12'h9A6);
    n = 0;
    for (int i = 0; i < 400 && adc_conv_n; i++) begin n++; @(negedge clk); end
    start = 1'b0;
    chk(n == ACQ + 1, "R9 strobe high gap", n, ACQ + 1);
    wait_outcome(v, e);
    chk(v && res_data == 12'h9A6, "R4 word after gap", res_data, 12'h9A6);
    @(negedge clk);
    // vector walk: R3 marker offsets, R4 data, R5 parking, R6 back-pressure, R8 timeout
    for (int vi = 0; vi < NV; vi++) begin
      int k, rd;
      k = int'(VEC[vi][31:24]); rd = int'(VEC[vi][23:16]);
      model_k = k; model_word = VEC[vi][11:0];
      ready = (rd == 0);
      start = 1'b1;
      wait_conv_low(ok);
      start = 1'b0;
      chk(ok, "R2 strobe falls on request", ok, 1);
      wait_outcome(v, e);
      if (k < ML) begin
        chk(v && !e, "R3 marker accepted", {v, e}, 2'b10);
        chk(res_data == VEC[vi][11:0], "R4 captured word", res_data, VEC[vi][11:0]);
        chk(adc_conv_n && !adc_sclk, "R5 strobe up and clock parked with valid",
            {adc_conv_n, adc_sclk}, 2'b10);
        ok = 1;
        for (int i = 0; i < rd; i++) begin
          @(negedge clk);
          if (!res_valid || res_data != VEC[vi][11:0]) ok = 0;
        end
        chk(ok, "R6 held under back-pressure", ok, 1);
        ready = 1'b1; @(negedge clk);
        chk(!res_valid, "R6 transfer completes", res_valid, 0);
      end else begin
        chk(e && !v, "R8 timeout flagged", {v, e}, 2'b01);
        @(negedge clk);
        chk(!timeout_err, "R8 error is one cycle", timeout_err, 0);
        n = 0;
        for (int i = 1; i < 40 && n == 0; i++) begin @(negedge clk); if (adc_conv_n) n = i; end
        chk(n == DH - 1 && !adc_sclk, "R8 strobe raised at clock fall", n, DH - 1);
        ok = 1;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (res_valid) ok = 0; end
        chk(ok, "R8 no result after timeout", ok, 1);
      end
    end
    chk(r10_bad == 0, "R10 clock low while strobe high", r10_bad, 0);
    finish_run();
  end
endmodule